// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the pool of unused physical register indices for a rename stage that handles several instructions per cycle. The pool is a ring buffer: allocation takes indices from the head, and registers released by retiring instructions are appended at the tail. The head and tail pointers each carry one wrap bit. Their difference is the number of free entries.

Each cycle, every rename lane that needs a new destination register raises its request bit. The block presents one candidate index per requesting lane and reports whether the pool can cover a whole rename group. The allocation is handshaked like a stream. `can_alloc` acts as the ready side and `do_alloc` as the valid side, and entries are consumed only in a cycle where both are high. While `can_alloc` is low, upstream must hold its group and retry.

When a mispredicted path is undone, the reorder buffer walks its entries backwards. During the walk the block rewinds its head by the supplied step count, so the registers that were handed out go back into the pool. A flush restores the state the block has after reset. A redirect cycle allocates nothing.

Top module: `preg_free_list`

## Requirements
- R1: After reset or flush the pool holds NUM_ARCH .. NUM_PREGS-1 in ascending order from the head, and the free count equals DEPTH = NUM_PREGS-NUM_ARCH.
- R2: `can_alloc` is 1 exactly when the free count is at least LANES.
- R3: Requesting lanes receive the entries at consecutive head positions in ascending lane order (lane 0 first). A lane without a request outputs index 0 and consumes no entry.
- R4: The head advances by the number of requesting lanes only in a cycle with `do_alloc`=1, `can_alloc`=1, no walk, no redirect and no flush. In any other cycle the same candidates are presented again.
- R5: `do_alloc` raised while `can_alloc` is 0 consumes nothing.
- R6: While `walk`=1 the head moves back by `step_back` entries, so the most recently handed-out registers are presented again in their original order.
- R7: A walk takes priority over `do_alloc` in the same cycle.
- R8: When not walking, each port with `free_req` set appends its `free_idx` at the tail, in ascending port order.
- R9: While `walk`=1 all `free_req` ports are ignored.
- R10: In a cycle with `redirect`=1, nothing is allocated. Frees in that cycle still take effect.
- R11: `flush` overrides walk, allocation and frees in the same cycle.
- R12: The head and tail pointers wrap around the ring without losing or repeating entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Restore the post-reset pool |
| redirect | input | 1 | Block allocation this cycle |
| walk | input | 1 | Recovery walk in progress |
| step_back | input | $clog2(FREE_PORTS+1) | Entries to rewind during a walk |
| alloc_req | input | LANES | Per-lane destination request |
| do_alloc | input | 1 | Commit the group allocation |
| can_alloc | output | 1 | At least LANES entries are free |
| alloc_idx | output | LANES x IDX_W | Candidate index per lane |
| free_req | input | FREE_PORTS | Per-port release request |
| free_idx | input | FREE_PORTS x IDX_W | Index released per port |

## Verification
Several functions can fall in the same cycle: a walk rewind, a group allocation and tail frees. The bench provokes this by raising `walk` together with `do_alloc`, all lane requests and all free ports. It judges the result in the following cycles by the candidate indices and `can_alloc`. The rewound head must present earlier indices again, and the ignored frees must never appear as candidates. The bench also combines frees with allocation and frees with redirect in one cycle. A reference ring model in the bench predicts every candidate index, including across pointer wrap.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD = 2'd0,
    PTR_INIT = 2'd1,
    PTR_BACK = 2'd2,
    PTR_FWD  = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/fl_prefix_count.sv
module fl_prefix_count #(
  parameter int N = 4,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0]        bits,
  output logic [N-1:0][W-1:0] rank,
  output logic [W-1:0]        total
);
  logic [W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      rank[i] = acc;
      acc = acc + W'(bits[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/fl_ring_ptr.sv
module fl_ring_ptr
  import fl_pkg::*;
#(
  parameter int PTR_W    = 5,
  parameter int AMT_W    = 3,
  parameter int INIT_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ptr_op_e          op,
  input  logic [AMT_W-1:0] amt,
  output logic [PTR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= PTR_W'(INIT_VAL);
    end else begin
      case (op)
        PTR_INIT: q <= PTR_W'(INIT_VAL);
        PTR_BACK: q <= q - PTR_W'(amt);
        PTR_FWD:  q <= q + PTR_W'(amt);
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/preg_free_list.sv
module preg_free_list
  import fl_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int FREE_PORTS = 4,
  parameter int NUM_PREGS  = 48,
  parameter int NUM_ARCH   = 32,
  localparam int IDX_W     = $clog2(NUM_PREGS),
  localparam int SB_W      = $clog2(FREE_PORTS + 1)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             redirect,
  input  logic                             walk,
  input  logic [SB_W-1:0]                  step_back,
  input  logic [LANES-1:0]                 alloc_req,
  input  logic                             do_alloc,
  output logic                             can_alloc,
  output logic [LANES-1:0][IDX_W-1:0]      alloc_idx,
  input  logic [FREE_PORTS-1:0]            free_req,
  input  logic [FREE_PORTS-1:0][IDX_W-1:0] free_idx
);
  localparam int DEPTH  = NUM_PREGS - NUM_ARCH;
  localparam int AW     = $clog2(DEPTH);
  localparam int PTR_W  = AW + 1;
  localparam int LCNT_W = $clog2(LANES + 1);
  localparam int FCNT_W = $clog2(FREE_PORTS + 1);
  localparam int HAMT_W = (SB_W > LCNT_W) ? SB_W : LCNT_W;

  logic [IDX_W-1:0] ring [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q, free_cnt;

  logic [LANES-1:0][LCNT_W-1:0]      a_rank;
  logic [LCNT_W-1:0]                 a_total;
  logic [FREE_PORTS-1:0][FCNT_W-1:0] f_rank;
  logic [FCNT_W-1:0]                 f_total;

  logic              alloc_fire;
  ptr_op_e           head_op, tail_op;
  logic [HAMT_W-1:0] head_amt;

  fl_prefix_count #(.N(LANES), .W(LCNT_W)) u_alloc_rank (
    .bits(alloc_req), .rank(a_rank), .total(a_total)
  );

  fl_prefix_count #(.N(FREE_PORTS), .W(FCNT_W)) u_free_rank (
    .bits(free_req), .rank(f_rank), .total(f_total)
  );

  assign free_cnt   = tail_q - head_q;
  assign can_alloc  = (free_cnt >= PTR_W'(LANES));
  assign alloc_fire = do_alloc && can_alloc && !walk && !redirect && !flush;

  always_comb begin
    if (flush)           head_op = PTR_INIT;
    else if (walk)       head_op = PTR_BACK;
    else if (alloc_fire) head_op = PTR_FWD;
    else                 head_op = PTR_HOLD;
    head_amt = walk ? HAMT_W'(step_back) : HAMT_W'(a_total);
  end

  always_comb begin
    if (flush)     tail_op = PTR_INIT;
    else if (walk) tail_op = PTR_HOLD;
    else           tail_op = PTR_FWD;
  end

  fl_ring_ptr #(.PTR_W(PTR_W), .AMT_W(HAMT_W), .INIT_VAL(0)) u_head (
    .clk(clk), .rst_n(rst_n), .op(head_op), .amt(head_amt), .q(head_q)
  );

  fl_ring_ptr #(.PTR_W(PTR_W), .AMT_W(FCNT_W), .INIT_VAL(DEPTH)) u_tail (
    .clk(clk), .rst_n(rst_n), .op(tail_op), .amt(f_total), .q(tail_q)
  );

  // candidate index per lane, taken from consecutive head slots
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [AW-1:0] slot;
    assign slot          = head_q[AW-1:0] + AW'(a_rank[ln]);
    assign alloc_idx[ln] = alloc_req[ln] ? ring[slot] : '0;
  end

  // tail write slots per free port
  logic [FREE_PORTS-1:0][AW-1:0] f_slot;
  for (genvar fp = 0; fp < FREE_PORTS; fp++) begin : g_free
    assign f_slot[fp] = tail_q[AW-1:0] + AW'(f_rank[fp]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ring[k] <= IDX_W'(NUM_ARCH + k);
    end else if (flush) begin
      for (int k = 0; k < DEPTH; k++) ring[k] <= IDX_W'(NUM_ARCH + k);
    end else if (!walk) begin
      for (int p = 0; p < FREE_PORTS; p++)
        if (free_req[p]) ring[f_slot[p]] <= free_idx[p];
    end
  end

  // R1: a flush leaves a full pool
  a_r1_flush_full: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (free_cnt == PTR_W'(DEPTH)));

  // R12: pointer distance never exceeds the ring
  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= PTR_W'(DEPTH));

  // R6: walk rewinds head by the step count
  a_r6_walk_rewind: assert property (@(posedge clk) disable iff (!rst_n)
    (walk && !flush) |=> (head_q == $past(head_q) - PTR_W'($past(step_back))));

  // R9: frees are dropped during a walk
  a_r9_walk_no_free: assert property (@(posedge clk) disable iff (!rst_n)
    (walk && !flush) |=> $stable(tail_q));

  // R5: a short pool never moves the head forward
  a_r5_short_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!can_alloc && !walk && !flush) |=> $stable(head_q));

  // R10: a redirect cycle leaves the head alone
  a_r10_redirect_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !walk && !flush) |=> $stable(head_q));
endmodule

// File: tb/tb_preg_free_list.sv
module tb_preg_free_list;
  localparam int LANES = 4, FP = 4, NP = 48, NA = 32;
  localparam int DEPTH = NP - NA, IW = $clog2(NP), SBW = $clog2(FP + 1);

  logic clk = 0, rst_n = 0;
  logic flush = 0, redirect = 0, walk = 0, do_alloc = 0;
  logic [SBW-1:0] step_back = '0;
  logic [LANES-1:0] alloc_req = '0;
  logic [FP-1:0] free_req = '0;
  logic [FP-1:0][IW-1:0] free_idx = '0;
  logic can_alloc;
  logic [LANES-1:0][IW-1:0] alloc_idx;

  always #5 clk = ~clk;

  preg_free_list dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .redirect(redirect), .walk(walk),
    .step_back(step_back), .alloc_req(alloc_req), .do_alloc(do_alloc),
    .can_alloc(can_alloc), .alloc_idx(alloc_idx), .free_req(free_req),
    .free_idx(free_idx)
  );

  typedef struct {
    logic can;
    int   idx [LANES];
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0, errors = 0;
  int mdl [DEPTH];
  int mh, mt;
  bit done = 0;

  function automatic int slot(int p);
    return ((p % DEPTH) + DEPTH) % DEPTH;
  endfunction

  function automatic void mdl_init();
    for (int k = 0; k < DEPTH; k++) mdl[k] = NA + k;
    mh = 0;
    mt = DEPTH;
  endfunction

  // driver: apply one cycle of stimulus, predict outputs, update model
  task automatic step(input logic fl, input logic rd, input logic wk, input int sbk,
                      input logic [LANES-1:0] ar, input logic da,
                      input logic [FP-1:0] fr, input logic [FP-1:0][IW-1:0] fi,
                      input string tag);
    exp_t e;
    int r;
    @(negedge clk);
    #1;
    flush = fl; redirect = rd; walk = wk; step_back = SBW'(sbk);
    alloc_req = ar; do_alloc = da; free_req = fr; free_idx = fi;
    e.can = ((mt - mh) >= LANES);
    e.tag = tag;
    r = 0;
    for (int i = 0; i < LANES; i++) begin
      if (ar[i]) begin e.idx[i] = mdl[slot(mh + r)]; r++; end
      else e.idx[i] = 0;
    end
    sb_q.push_back(e);
    if (fl) mdl_init();
    else if (wk) mh = mh - sbk;
    else begin
      if (da && e.can && !rd) mh = mh + r;
      for (int p = 0; p < FP; p++)
        if (fr[p]) begin mdl[slot(mt)] = int'(fi[p]); mt++; end
    end
  endtask

  // monitor: compare just before the next rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        checks++;
        if (can_alloc !== e.can) begin
          errors++;
          $display("FAIL %s can_alloc actual=%0d expected=%0d", e.tag, can_alloc, e.can);
        end
        for (int i = 0; i < LANES; i++) begin
          checks++;
          if (int'(alloc_idx[i]) != e.idx[i]) begin
            errors++;
            $display("FAIL %s lane%0d alloc_idx actual=%0d expected=%0d",
                     e.tag, i, alloc_idx[i], e.idx[i]);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [FP-1:0] fr;
    int cnt, sbk;
    mdl_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset contents presented on all lanes
    step(0, 0, 0, 0, 4'b1111, 0, '0, '0, "R1");
    // R3: sparse lanes take consecutive entries
    step(0, 0, 0, 0, 4'b1010, 1, '0, '0, "R3");
    step(0, 0, 0, 0, 4'b1111, 0, '0, '0, "R4");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R4");
    // R7 R9: walk with do_alloc and frees in the same cycle
    step(0, 0, 1, 3, 4'b1111, 1, 4'b1111, {6'd1, 6'd2, 6'd3, 6'd4}, "R7");
    step(0, 0, 0, 0, 4'b1111, 0, '0, '0, "R6");
    // R10: redirect blocks allocation
    step(0, 1, 0, 0, 4'b1111, 1, '0, '0, "R10");
    step(0, 0, 0, 0, 4'b1111, 0, '0, '0, "R10");
    // R11: flush overrides frees and allocation
    step(1, 0, 0, 0, 4'b1111, 1, 4'b1111, {6'd9, 6'd9, 6'd9, 6'd9}, "R11");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R1");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R4");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R4");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R4");
    // R2 R5: empty pool ignores do_alloc
    step(0, 0, 0, 0, 4'b0011, 1, '0, '0, "R5");
    step(0, 0, 0, 0, 4'b0001, 0, '0, '0, "R5");
    // R8: frees land in port order at the tail
    step(0, 0, 0, 0, 4'b0000, 0, 4'b1101, {6'd7, 6'd0, 6'd6, 6'd5}, "R8");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R2");
    step(0, 0, 0, 0, 4'b0000, 0, 4'b0001, {6'd0, 6'd0, 6'd0, 6'd8}, "R8");
    step(0, 0, 0, 0, 4'b1111, 0, '0, '0, "R2");
    step(0, 0, 0, 0, 4'b1111, 1, '0, '0, "R8");
    // R12: long mixed traffic wrapping the ring
    lf = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cnt = mt - mh;
      fr = lf[19:16];
      if ($countones(fr) > DEPTH - cnt) fr = '0;
      if (lf[2:0] == 3'b111) begin
        sbk = int'(lf[5:3]) % (FP + 1);
        if (sbk > DEPTH - cnt) sbk = DEPTH - cnt;
        step(0, 0, 1, sbk, lf[11:8], lf[12], fr, lf[23:0], "R12");
      end else begin
        step(lf[31:26] == 6'd0, lf[24:20] == 5'd0, 0, 0, lf[11:8],
             lf[12] | lf[13], fr, lf[23:0], "R12");
      end
    end
    @(negedge clk);
    #6;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule